// File: doc/BRIEF.md
# Performance Monitor Counter Bank

A bank of ten 48-bit event counters for a processor core's performance monitor. Counter 0 advances on every clock and counter 1 advances on every retired-instruction pulse. Counters 2 to 9 each pick one line of a 256-wide event-pulse bus through an 8-bit selector. Every counter has its own run enable, its own overflow-interrupt enable and separate gates for user and kernel privilege. A counter advances only when its run enable is set and the gate for the current privilege is also set.

When an increment carries bit 47 from zero to one, the counter's bit in an overflow status register is set, but only if that counter's interrupt enable is on. A single interrupt line is raised while any status bit is pending and the interrupt mode is not off. Raising it also latches an interrupt-active flag, which software clears by writing zero. The status register can then be read to tell a real overflow from a spurious interrupt.

Software reaches everything through a flat register port: one write strobe, an address, write data and combinational read data. Counters can be written directly.

Top module: `pmc_bank`

## Requirements
- R1: After reset all counters read zero, all run enables and interrupt enables are clear, the interrupt mode is off (0), the status register is zero and `irq` is low.
- R2: Counter 0 adds one on each clock edge and counter 1 adds one on each edge where `instr_retired` is high, provided it is enabled and allowed at the current privilege.
- R3: Counters 2 to 9 count `evt_pulse[s]`, where s is their selector. The selectors of counters 2 to 5 sit in register 2 at bits (k-2)*8 and up, and those of counters 6 to 9 sit in register 3 at bits (k-6)*8 and up. A pulse on any other line is not counted.
- R4: The filter register (address 1) holds user gates in bits 9:0 and kernel gates in bits 25:16, one bit per counter. `priv_kernel`=1 selects the kernel gate and 0 selects the user gate.
- R5: In the control register (address 0), run enables for counters 0 to 7 are bits 7:0 and for counters 8 and 9 are bits 33:32. A counter whose enable is clear holds its value.
- R6: An increment that takes bit 47 from 0 to 1 sets that counter's bit in the status register (address 4, bit k) on the same edge, only when the counter's interrupt enable is set (control bits 23:16 for counters 0 to 7, bits 41:40 for counters 8 and 9). The all-ones value wraps to zero and sets no status.
- R7: Writing the status register clears the bits written as one and leaves the bits written as zero. A new overflow on the same edge wins over the clear.
- R8: `irq` is high while a status bit is set and the mode field (control bits 9:8; 0 = off, 1 = fast interrupt) is non-zero. Each edge with `irq` high sets the active flag (control bit 10), and a control write of 0 to that bit clears it when `irq` is low.
- R9: Counter k is written at address 8+k and the new value appears on the next edge. If a write and an event arrive on the same edge, the written value is kept and that increment is dropped.
- R10: Configuration registers read back the written value in the defined fields and zero in every other bit. Counters read back zero-extended to 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` (combinational) |
| evt_pulse | input | 256 | One pulse line per selectable event |
| instr_retired | input | 1 | Retired-instruction pulse for counter 1 |
| priv_kernel | input | 1 | Current privilege: 1 kernel, 0 user |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench builds the block with its default parameters: ten counters, 48-bit width and 8-bit selectors over 256 event lines. With these values both selector registers, the split enable fields and both counter groups are exercised. Because counters can be written directly, a counter can be preloaded just below bit 47 or just below all ones. One event pulse then reaches the overflow and wrap boundaries, without 2^47 cycles of counting.

// File: rtl/pmc_pkg.sv
// Package: shared sizes, register addresses and field positions of the
// counter bank. Assumes ten counters split into a group of eight and a group
// of two within the control word.
package pmc_pkg;
    localparam int PMC_NCTR    = 10;
    localparam int PMC_CTR_W   = 48;
    localparam int PMC_SEL_W   = 8;
    localparam int PMC_DATA_W  = 64;
    localparam int PMC_ADDR_W  = 5;
    localparam int PMC_LO_GRP  = 8;   // counters in the low enable group
    localparam int FIXED_CNT   = 2;   // counters with a fixed event
    localparam int SEL_PER_REG = 4;   // selectors packed into one register

    // register addresses
    localparam int A_CTL      = 0;
    localparam int A_FILT     = 1;
    localparam int A_SELA     = 2;
    localparam int A_SELB     = 3;
    localparam int A_STAT     = 4;
    localparam int A_CTR_BASE = 8;

    // control word layout
    localparam int CTL_MODE_LSB  = 8;
    localparam int CTL_MODE_W    = 2;
    localparam int CTL_ACT_BIT   = 10;
    localparam int CTL_IE_LO_LSB = 16;
    localparam int CTL_EN_HI_LSB = 32;
    localparam int CTL_IE_HI_LSB = 40;
    localparam int FILT_KRN_LSB  = 16;

    localparam logic [CTL_MODE_W-1:0] IRQ_OFF  = 2'd0;
    localparam logic [CTL_MODE_W-1:0] IRQ_FAST = 2'd1;

    // bit of counter k's run enable in the control word
    function automatic int en_bit(input int k);
        return (k < PMC_LO_GRP) ? k : CTL_EN_HI_LSB + k - PMC_LO_GRP;
    endfunction

    // bit of counter k's interrupt enable in the control word
    function automatic int ie_bit(input int k);
        return (k < PMC_LO_GRP) ? CTL_IE_LO_LSB + k : CTL_IE_HI_LSB + k - PMC_LO_GRP;
    endfunction

    // low bit of counter k's selector inside its select register
    function automatic int sel_lsb(input int k);
        return ((k - FIXED_CNT) % SEL_PER_REG) * PMC_SEL_W;
    endfunction

    // true when counter k's selector lives in the second select register
    function automatic bit sel_in_b(input int k);
        return (k - FIXED_CNT) >= SEL_PER_REG;
    endfunction
endpackage

// File: rtl/pmc_counter.sv
// One event counter. Loads on a write, else adds one on inc. Flags the
// carry of the top bit from 0 to 1 caused by an increment. Assumes a write
// on the same edge drops the increment.
module pmc_counter #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value,
    output logic         ovf
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nxt;

    // incremented value, wrapping at W bits
    assign cnt_nxt = cnt_q + W'(1);

    // counter register: write has priority over increment
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (wr)  cnt_q <= wdata;
        else if (inc) cnt_q <= cnt_nxt;
    end

    // top bit rises because of an increment that is actually taken
    assign ovf   = inc && !wr && !cnt_q[W-1] && cnt_nxt[W-1];
    assign value = cnt_q;
endmodule

// File: rtl/pmc_event_route.sv
// Per-counter increment request. Picks the raw event (clock, retired
// instruction or a selected bus line), then gates it by the run enable and
// the privilege gate. Assumes the event lines are single-cycle pulses.
module pmc_event_route
    import pmc_pkg::*;
#(
    parameter int NCTR  = PMC_NCTR,
    parameter int SEL_W = PMC_SEL_W,
    parameter int NEVT  = 2**PMC_SEL_W
) (
    input  logic [NEVT-1:0]             evt_pulse,
    input  logic                        instr_retired,
    input  logic                        priv_kernel,
    input  logic [NCTR-1:0]             cnt_en,
    input  logic [NCTR-1:0]             usr_en,
    input  logic [NCTR-1:0]             krn_en,
    input  logic [NCTR-1:0][SEL_W-1:0]  sel,
    output logic [NCTR-1:0]             inc
);
    logic [NCTR-1:0] raw;
    logic [NCTR-1:0] priv_ok;

    for (genvar k = 0; k < NCTR; k++) begin : g_route
        if (k == 0) begin : g_cyc
            // fixed: every clock
            assign raw[k] = 1'b1;
        end else if (k == 1) begin : g_ins
            // fixed: retired instructions
            assign raw[k] = instr_retired;
        end else begin : g_sel
            // programmable: selected bus line
            assign raw[k] = evt_pulse[sel[k]];
        end
        // privilege gate matching the current level
        assign priv_ok[k] = priv_kernel ? krn_en[k] : usr_en[k];
        assign inc[k]     = raw[k] && cnt_en[k] && priv_ok[k];
    end
endmodule

// File: rtl/pmc_ctrl_regs.sv
// Configuration and status registers of the counter bank: control word,
// privilege filter, two packed selector registers and overflow status.
// Produces the interrupt and the read data for configuration addresses.
// Assumes a single write strobe and a combinational read.
module pmc_ctrl_regs
    import pmc_pkg::*;
#(
    parameter int NCTR   = PMC_NCTR,
    parameter int SEL_W  = PMC_SEL_W,
    parameter int DATA_W = PMC_DATA_W,
    parameter int ADDR_W = PMC_ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [NCTR-1:0]            ovf_hit,
    output logic [NCTR-1:0]            cnt_en,
    output logic [NCTR-1:0]            irq_en,
    output logic [NCTR-1:0]            usr_en,
    output logic [NCTR-1:0]            krn_en,
    output logic [NCTR-1:0][SEL_W-1:0] sel,
    output logic [NCTR-1:0]            status,
    output logic                       irq_active,
    output logic                       irq,
    output logic [DATA_W-1:0]          cfg_rdata
);
    logic [NCTR-1:0]            en_q, ie_q, usr_q, krn_q, stat_q;
    logic [NCTR-1:0][SEL_W-1:0] sel_q;
    logic [CTL_MODE_W-1:0]      mode_q;
    logic                       act_q;
    logic                       wr_ctl, wr_filt, wr_sela, wr_selb, wr_stat;
    logic [NCTR-1:0]            stat_clr;

    // address decode of the write strobe
    assign wr_ctl  = we && (addr == ADDR_W'(A_CTL));
    assign wr_filt = we && (addr == ADDR_W'(A_FILT));
    assign wr_sela = we && (addr == ADDR_W'(A_SELA));
    assign wr_selb = we && (addr == ADDR_W'(A_SELB));
    assign wr_stat = we && (addr == ADDR_W'(A_STAT));

    // run enables, interrupt enables and mode from the control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            ie_q   <= '0;
            mode_q <= IRQ_OFF;
        end else if (wr_ctl) begin
            for (int k = 0; k < NCTR; k++) begin
                en_q[k] <= wdata[en_bit(k)];
                ie_q[k] <= wdata[ie_bit(k)];
            end
            mode_q <= wdata[CTL_MODE_LSB +: CTL_MODE_W];
        end
    end

    // interrupt-active flag: software writes it, a live interrupt sets it
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= (wr_ctl ? wdata[CTL_ACT_BIT] : act_q) | irq;
    end

    // privilege filter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usr_q <= '0;
            krn_q <= '0;
        end else if (wr_filt) begin
            usr_q <= wdata[NCTR-1:0];
            krn_q <= wdata[FILT_KRN_LSB +: NCTR];
        end
    end

    // packed selectors; fixed counters keep their reset value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            for (int k = FIXED_CNT; k < NCTR; k++) begin
                if (wr_sela && !sel_in_b(k))
                    sel_q[k] <= wdata[sel_lsb(k) +: SEL_W];
                else if (wr_selb && sel_in_b(k))
                    sel_q[k] <= wdata[sel_lsb(k) +: SEL_W];
            end
        end
    end

    // write-one-to-clear mask for the status register
    assign stat_clr = wr_stat ? wdata[NCTR-1:0] : '0;

    // overflow status: a new overflow wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | (ovf_hit & ie_q);
    end

    // interrupt line: pending status and a delivering mode
    assign irq = (|stat_q) && (mode_q != IRQ_OFF);

    // read data for configuration addresses, zero elsewhere
    always_comb begin
        cfg_rdata = '0;
        if (addr == ADDR_W'(A_CTL)) begin
            for (int k = 0; k < NCTR; k++) begin
                cfg_rdata[en_bit(k)] = en_q[k];
                cfg_rdata[ie_bit(k)] = ie_q[k];
            end
            cfg_rdata[CTL_MODE_LSB +: CTL_MODE_W] = mode_q;
            cfg_rdata[CTL_ACT_BIT]                = act_q;
        end else if (addr == ADDR_W'(A_FILT)) begin
            cfg_rdata[NCTR-1:0]              = usr_q;
            cfg_rdata[FILT_KRN_LSB +: NCTR]  = krn_q;
        end else if (addr == ADDR_W'(A_SELA)) begin
            for (int k = FIXED_CNT; k < NCTR; k++)
                if (!sel_in_b(k)) cfg_rdata[sel_lsb(k) +: SEL_W] = sel_q[k];
        end else if (addr == ADDR_W'(A_SELB)) begin
            for (int k = FIXED_CNT; k < NCTR; k++)
                if (sel_in_b(k)) cfg_rdata[sel_lsb(k) +: SEL_W] = sel_q[k];
        end else if (addr == ADDR_W'(A_STAT)) begin
            cfg_rdata[NCTR-1:0] = stat_q;
        end
    end

    assign cnt_en     = en_q;
    assign irq_en     = ie_q;
    assign usr_en     = usr_q;
    assign krn_en     = krn_q;
    assign sel        = sel_q;
    assign status     = stat_q;
    assign irq_active = act_q;
endmodule

// File: rtl/pmc_bank.sv
// Top of the performance counter bank: configuration registers, event
// routing, one counter per index and the read multiplexer. Assumes counters
// occupy consecutive addresses starting at A_CTR_BASE.
module pmc_bank
    import pmc_pkg::*;
#(
    parameter int  NCTR   = PMC_NCTR,
    parameter int  CTR_W  = PMC_CTR_W,
    parameter int  SEL_W  = PMC_SEL_W,
    parameter int  DATA_W = PMC_DATA_W,
    parameter int  ADDR_W = PMC_ADDR_W,
    localparam int NEVT   = 2**SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NEVT-1:0]   evt_pulse,
    input  logic              instr_retired,
    input  logic              priv_kernel,
    output logic              irq
);
    logic [NCTR-1:0]             cnt_en, irq_en, usr_en, krn_en, ovf_status;
    logic [NCTR-1:0][SEL_W-1:0]  sel;
    logic [NCTR-1:0][CTR_W-1:0]  ctr_val;
    logic [NCTR-1:0]             ctr_inc, ctr_wr, ctr_ovf;
    logic                        irq_active;
    logic [DATA_W-1:0]           cfg_rdata;

    pmc_ctrl_regs #(
        .NCTR(NCTR), .SEL_W(SEL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .ovf_hit(ctr_ovf), .cnt_en(cnt_en),
        .irq_en(irq_en), .usr_en(usr_en), .krn_en(krn_en), .sel(sel),
        .status(ovf_status), .irq_active(irq_active), .irq(irq),
        .cfg_rdata(cfg_rdata)
    );

    pmc_event_route #(
        .NCTR(NCTR), .SEL_W(SEL_W), .NEVT(NEVT)
    ) u_route (
        .evt_pulse(evt_pulse), .instr_retired(instr_retired),
        .priv_kernel(priv_kernel), .cnt_en(cnt_en), .usr_en(usr_en),
        .krn_en(krn_en), .sel(sel), .inc(ctr_inc)
    );

    for (genvar k = 0; k < NCTR; k++) begin : g_ctr
        // direct write decode for counter k
        assign ctr_wr[k] = reg_we && (reg_addr == ADDR_W'(A_CTR_BASE + k));

        pmc_counter #(.W(CTR_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .inc(ctr_inc[k]), .wr(ctr_wr[k]),
            .wdata(reg_wdata[CTR_W-1:0]), .value(ctr_val[k]),
            .ovf(ctr_ovf[k])
        );
    end

    // read multiplexer: counter addresses override configuration data
    always_comb begin
        reg_rdata = cfg_rdata;
        for (int k = 0; k < NCTR; k++)
            if (reg_addr == ADDR_W'(A_CTR_BASE + k))
                reg_rdata = DATA_W'(ctr_val[k]);
    end
endmodule

// File: rtl/pmc_bank_chk.sv
// Checker for pmc_bank: counter stepping, holding and loading on counter 0,
// status gating by interrupt enable, and the interrupt-active latch.
module pmc_bank_chk
    import pmc_pkg::*;
#(
    parameter int NCTR  = PMC_NCTR,
    parameter int CTR_W = PMC_CTR_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CTR_W-1:0] wr_data,
    input logic             irq,
    input logic             irq_active,
    input logic [NCTR-1:0]  status,
    input logic [NCTR-1:0]  irq_en,
    input logic [CTR_W-1:0] ctr0,
    input logic             inc0,
    input logic             wr0
);
    // R8
    irq_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> irq_active);

    // R9
    ctr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr0 |=> ctr0 == $past(wr_data));

    // R2
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc0 && !wr0) |=> ctr0 == $past(ctr0) + CTR_W'(1));

    // R5
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc0 && !wr0) |=> $stable(ctr0));

    for (genvar k = 0; k < NCTR; k++) begin : g_stat
        // R6
        ovf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq_en[k] && !status[k]) |=> !status[k]);
    end
endmodule

bind pmc_bank pmc_bank_chk #(.NCTR(NCTR), .CTR_W(CTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_data(reg_wdata[CTR_W-1:0]), .irq(irq),
    .irq_active(irq_active), .status(ovf_status), .irq_en(irq_en),
    .ctr0(ctr_val[0]), .inc0(ctr_inc[0]), .wr0(ctr_wr[0])
);

// File: tb/pmc_bank_tb.sv
`timescale 1ns/1ps
// Bench for pmc_bank: a vector table for selector counting, then directed
// tests for reset, fixed counters, privilege, enable groups, overflow,
// status clearing, interrupt and readback.
module pmc_bank_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [4:0]   reg_addr = '0;
    logic [63:0]  reg_wdata = '0;
    logic [63:0]  reg_rdata;
    logic [255:0] evt_pulse = '0;
    logic         instr_retired = 1'b0;
    logic         priv_kernel = 1'b0;
    logic         irq;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;
    logic [63:0]  rv;

    // {counter index[19:16], selector[15:8], pulse count[7:0]}
    localparam logic [19:0] VEC [6] = '{
        20'h2_10_03, 20'h3_22_05, 20'h5_FF_01,
        20'h6_00_04, 20'h7_81_02, 20'h8_7E_06
    };

    always #4 clk = ~clk;

    pmc_bank u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .instr_retired(instr_retired), .priv_kernel(priv_kernel), .irq(irq)
    );

    // control word built from the layout in R5, R6, R8
    function automatic logic [63:0] ctl_w(input logic [9:0] en, input logic [9:0] ie,
                                          input logic [1:0] mode, input logic act);
        logic [63:0] v = '0;
        v[7:0]   = en[7:0];
        v[33:32] = en[9:8];
        v[23:16] = ie[7:0];
        v[41:40] = ie[9:8];
        v[9:8]   = mode;
        v[10]    = act;
        return v;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input int line, input int n);
        @(negedge clk);
        evt_pulse[line] = 1'b1;
        repeat (n) @(negedge clk);
        evt_pulse[line] = 1'b0;
    endtask

    task automatic set_sel(input int idx, input logic [7:0] s);
        wr((idx < 6) ? 5'd2 : 5'd3, 64'(s) << (((idx - 2) % 4) * 8));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog (all): actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(5'(a), rv); check("R1 config reg", rv, 64'h0);
        end
        for (int k = 0; k < 10; k++) begin
            rd(5'(8 + k), rv); check("R1 counter", rv, 64'h0);
        end
        check("R1 irq", {63'h0, irq}, 64'h0);

        // R10: filter and selector readback
        wr(5'd1, '1); rd(5'd1, rv); check("R10 filter readback", rv, 64'h0000_0000_03FF_03FF);
        wr(5'd2, '1); rd(5'd2, rv); check("R10 selector readback", rv, 64'h0000_0000_FFFF_FFFF);
        wr(5'd2, '0);

        // R3: vector table over programmable counters
        for (int i = 0; i < 6; i++) begin
            int idx;
            int s;
            int n;
            idx = int'(VEC[i][19:16]);
            s   = int'(VEC[i][15:8]);
            n   = int'(VEC[i][7:0]);
            wr(5'(8 + idx), 64'h0);
            set_sel(idx, 8'(s));
            wr(5'd0, ctl_w(10'(1) << idx, '0, 2'd0, 1'b0));
            pulse(s ^ 1, n);           // other line: not counted
            pulse(s, n);
            rd(5'(8 + idx), rv);
            check("R3 selected event count", rv, 64'(n));
            wr(5'd0, 64'h0);
        end

        // R2: counter 0 counts clocks (7 edges between the two writes)
        wr(5'd8, 64'h0);
        wr(5'd0, ctl_w(10'h001, '0, 2'd0, 1'b0));
        repeat (5) @(negedge clk);
        wr(5'd0, 64'h0);
        rd(5'd8, rv); check("R2 cycle counter", rv, 64'd7);

        // R5: disabled counter 0 holds
        repeat (4) @(negedge clk);
        rd(5'd8, rv); check("R5 disabled counter holds", rv, 64'd7);

        // R2: counter 1 counts retired instructions
        wr(5'd9, 64'h0);
        wr(5'd0, ctl_w(10'h002, '0, 2'd0, 1'b0));
        @(negedge clk); instr_retired = 1'b1;
        repeat (6) @(negedge clk); instr_retired = 1'b0;
        repeat (2) @(negedge clk);
        rd(5'd9, rv); check("R2 instruction counter", rv, 64'd6);

        // R9: write beats a same-edge increment on counter 0
        wr(5'd0, ctl_w(10'h001, '0, 2'd0, 1'b0));
        wr(5'd8, 64'd100);
        rd(5'd8, rv); check("R9 write wins over increment", rv, 64'd100);
        wr(5'd0, 64'h0);

        // R4: privilege gating on counter 2
        wr(5'd10, 64'h0);
        set_sel(2, 8'h33);
        wr(5'd1, 64'h0000_0000_0000_0004);   // user gate only
        wr(5'd0, ctl_w(10'h004, '0, 2'd0, 1'b0));
        priv_kernel = 1'b1;
        pulse(8'h33, 4);
        rd(5'd10, rv); check("R4 kernel blocked", rv, 64'd0);
        priv_kernel = 1'b0;
        pulse(8'h33, 3);
        rd(5'd10, rv); check("R4 user counted", rv, 64'd3);
        wr(5'd1, 64'h0000_0000_0004_0000);   // kernel gate only
        priv_kernel = 1'b1;
        pulse(8'h33, 2);
        rd(5'd10, rv); check("R4 kernel counted", rv, 64'd5);
        priv_kernel = 1'b0;
        pulse(8'h33, 2);
        rd(5'd10, rv); check("R4 user blocked", rv, 64'd5);
        wr(5'd1, 64'h0000_0000_03FF_03FF);

        // R5: high enable group, counter 9 on, counter 8 off, same event
        wr(5'd16, 64'h0); wr(5'd17, 64'h0);
        wr(5'd3, 64'h4444_0000);
        wr(5'd0, ctl_w(10'h200, '0, 2'd0, 1'b0));
        pulse(8'h44, 5);
        rd(5'd17, rv); check("R5 counter 9 enabled", rv, 64'd5);
        rd(5'd16, rv); check("R5 counter 8 disabled", rv, 64'd0);

        // R6/R8: overflow on counter 3 with interrupt enabled
        set_sel(3, 8'h20);
        wr(5'd11, 64'h0000_7FFF_FFFF_FFFF);
        wr(5'd0, ctl_w(10'h008, 10'h008, 2'd1, 1'b0));
        pulse(8'h20, 1);
        rd(5'd11, rv); check("R6 counter crosses bit 47", rv, 64'h0000_8000_0000_0000);
        rd(5'd4, rv);  check("R6 status bit 3", rv, 64'h8);
        check("R8 irq raised", {63'h0, irq}, 64'h1);
        @(negedge clk);
        rd(5'd0, rv); check("R8 active flag set", {63'h0, rv[10]}, 64'h1);
        wr(5'd0, ctl_w(10'h008, 10'h008, 2'd0, 1'b1));
        check("R8 mode off masks irq", {63'h0, irq}, 64'h0);

        // R7: write-one-to-clear
        wr(5'd4, 64'h0);
        rd(5'd4, rv); check("R7 zero write keeps status", rv, 64'h8);
        wr(5'd4, 64'h8);
        rd(5'd4, rv); check("R7 one write clears status", rv, 64'h0);

        // R8: spurious case, active flag cleared by software
        wr(5'd0, ctl_w('0, '0, 2'd1, 1'b0));
        rd(5'd0, rv); check("R8 active flag cleared", {63'h0, rv[10]}, 64'h0);
        check("R8 irq low with empty status", {63'h0, irq}, 64'h0);

        // R6: overflow without interrupt enable sets no status
        set_sel(4, 8'h21);
        wr(5'd12, 64'h0000_7FFF_FFFF_FFFF);
        wr(5'd0, ctl_w(10'h010, '0, 2'd1, 1'b0));
        pulse(8'h21, 1);
        rd(5'd12, rv); check("R6 counter 4 crosses", rv, 64'h0000_8000_0000_0000);
        rd(5'd4, rv);  check("R6 masked overflow no status", rv, 64'h0);

        // R6: wrap from all ones sets no status
        wr(5'd12, 64'h0000_FFFF_FFFF_FFFF);
        wr(5'd0, ctl_w(10'h010, 10'h010, 2'd1, 1'b0));
        pulse(8'h21, 1);
        rd(5'd12, rv); check("R6 wrap to zero", rv, 64'h0);
        rd(5'd4, rv);  check("R6 wrap no status", rv, 64'h0);
        check("R8 no irq after wrap", {63'h0, irq}, 64'h0);

        done = 1'b1;
        finish_run();
    end
endmodule